// File: doc/BRIEF.md
# Palette Entry Format Converter

This block turns a raw colour-lookup buffer into a table of 24-bit colour entries. Each output entry also carries one transparency bit. A single conversion walks the buffer one entry per clock. It unpacks each stored entry according to one of four packed layouts and writes the result into a palette RAM through a plain write port. The number of entries follows the pixel depth: 4, 16 or 256. A monochrome switch replaces the colour fields with a grey level taken from the low byte of each entry.

A conversion starts on an explicit strobe. Once any conversion has been accepted, the block also restarts by itself whenever the layout select no longer matches the layout recorded at the last accepted start. This keeps the palette consistent with the layout field without software involvement. The buffer read port is combinational: the block presents a byte address, and the buffer returns the four bytes starting there in little-endian order. Filling that buffer from memory and drawing pixels happen elsewhere.

Top module: `pal_fmt_conv`

## Requirements
- R1: The depth code sets the entry count: code 1 gives 4 entries, code 2 gives 16 and code 3 gives 256. Writes start the cycle after the start is accepted and use addresses 0 up to count-1, rising by one on each consecutive clock.
- R2: A start with any other depth code writes nothing and raises `done` the cycle after.
- R3: Layout 0 stores entry i in bytes 2i (low) and 2i+1. Red is bits 15:11, green is bits 10:5 and blue is bits 4:0, each placed at the top of its 8-bit output field with zeros below. Transparency is 0.
- R4: Layout 1 stores entry i in bytes 4i..4i+3, little-endian. Red is bits 23:19, green is bits 15:10 and blue is bits 7:3, each at the top of its 8-bit field. Transparency is bit 24.
- R5: Layout 2 uses the same storage as layout 1. Red is bits 23:18, green is bits 15:10 and blue is bits 7:2, each at the top of its 8-bit field. Transparency is bit 24.
- R6: Layout 3 uses the same storage as layout 1. Red is bits 23:16, green is bits 15:8 and blue is bits 7:0. Transparency is bit 24.
- R7: In monochrome mode, red, green and blue all equal bits 7:0 of the stored entry. Transparency still follows the layout: 0 for layout 0, bit 24 otherwise.
- R8: Output word layout is {transparency, red[7:0], green[7:0], blue[7:0]} in bits 24..0. `done` is 0 after reset. It drops when a start is accepted and rises after the last write, staying high until the next accepted start.
- R9: A start strobe that arrives while a conversion is running is ignored. No extra writes result.
- R10: When idle, after at least one accepted start, with a valid depth code and a layout select different from the one recorded at the last accepted start, the block starts a conversion on its own at the next edge.
- R11: Layout, monochrome and depth are sampled when a start is accepted. Changing them during a run does not alter that run's entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe, one cycle |
| fmt | input | 2 | Stored entry layout select (0..3) |
| depth | input | 4 | Pixel depth code (1, 2, 3 valid) |
| mono | input | 1 | Monochrome override |
| buf_addr | output | 10 | Byte address of the current entry in the buffer |
| buf_rdata | input | 32 | Four bytes from `buf_addr` upward, little-endian |
| pal_we | output | 1 | Palette write enable |
| pal_waddr | output | 8 | Palette write index |
| pal_wdata | output | 25 | Converted entry {transparency, R, G, B} |
| done | output | 1 | Last conversion finished |

## Verification
The assertions assume that `buf_rdata` is a pure function of `buf_addr` for the whole run, meaning the buffer is not rewritten mid-conversion. The bench fills its byte array only while the block is idle and never touches it afterwards. The bench drives all inputs on the falling edge, and it changes the layout select during a run only where it wants the automatic rerun. Whenever the bench changes the layout select, it pushes the expected entries of that rerun into its reference queue.

// File: rtl/pal_fmt_conv.sv
module pal_fmt_conv (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  fmt,
  input  logic [3:0]  depth,
  input  logic        mono,
  output logic [9:0]  buf_addr,
  input  logic [31:0] buf_rdata,
  output logic        pal_we,
  output logic [7:0]  pal_waddr,
  output logic [24:0] pal_wdata,
  output logic        done
);

  logic       busy, armed, mono_q;
  logic [1:0] fmt_q;
  logic [7:0] idx, last_q, last_new;
  logic       depth_ok, kick;

  always_comb begin
    depth_ok = 1'b1;
    last_new = 8'd0;
    case (depth)
      4'd1:    last_new = 8'd3;
      4'd2:    last_new = 8'd15;
      4'd3:    last_new = 8'd255;
      default: depth_ok = 1'b0;
    endcase
  end

  assign kick = !busy && (start || (armed && depth_ok && fmt != fmt_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      armed  <= 1'b0;
      fmt_q  <= 2'd0;
      mono_q <= 1'b0;
      idx    <= 8'd0;
      last_q <= 8'd0;
    end else if (kick) begin
      armed  <= 1'b1;
      fmt_q  <= fmt;
      mono_q <= mono;
      idx    <= 8'd0;
      last_q <= last_new;
      busy   <= depth_ok;
      done   <= !depth_ok;
    end else if (busy) begin
      if (idx == last_q) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        idx <= idx + 8'd1;
      end
    end
  end

  assign buf_addr  = (fmt_q == 2'd0) ? {1'b0, idx, 1'b0} : {idx, 2'b00};
  assign pal_we    = busy;
  assign pal_waddr = idx;

  logic [7:0] r, g, b;
  logic       t;

  always_comb begin
    t = (fmt_q != 2'd0) && buf_rdata[24];
    case (fmt_q)
      2'd0: begin
        r = {buf_rdata[15:11], 3'b000};
        g = {buf_rdata[10:5], 2'b00};
        b = {buf_rdata[4:0], 3'b000};
      end
      2'd1: begin
        r = {buf_rdata[23:19], 3'b000};
        g = {buf_rdata[15:10], 2'b00};
        b = {buf_rdata[7:3], 3'b000};
      end
      2'd2: begin
        r = {buf_rdata[23:18], 2'b00};
        g = {buf_rdata[15:10], 2'b00};
        b = {buf_rdata[7:2], 2'b00};
      end
      default: begin
        r = buf_rdata[23:16];
        g = buf_rdata[15:8];
        b = buf_rdata[7:0];
      end
    endcase
    if (mono_q) begin
      r = buf_rdata[7:0];
      g = buf_rdata[7:0];
      b = buf_rdata[7:0];
    end
  end

  assign pal_wdata = {t, r, g, b};

  p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we && $past(pal_we) |-> pal_waddr == $past(pal_waddr) + 8'd1);

  p_first_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pal_we) |-> pal_waddr == 8'd0);

  p_no_done_while_writing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we |-> !done);

  p_fmt0_opaque_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we && buf_addr[1:0] == 2'b10 |-> !pal_wdata[24]);

  p_mono_grey_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we && mono_q |-> pal_wdata[23:16] == pal_wdata[7:0] && pal_wdata[15:8] == pal_wdata[7:0]);

  p_run_not_cut_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we && pal_waddr != last_q |=> pal_we && $stable(fmt_q));

endmodule

// File: tb/tb_pal_fmt_conv.sv
module tb_pal_fmt_conv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic [3:0]  depth = 4'd0;
  logic        mono = 1'b0;
  logic [9:0]  buf_addr;
  logic [31:0] buf_rdata;
  logic        pal_we;
  logic [7:0]  pal_waddr;
  logic [24:0] pal_wdata;
  logic        done;

  always #10 clk = ~clk;

  pal_fmt_conv dut (.*);

  byte unsigned mem [0:1031];
  always_comb buf_rdata = {mem[int'(buf_addr)+3], mem[int'(buf_addr)+2],
                           mem[int'(buf_addr)+1], mem[int'(buf_addr)]};

  int checks = 0, errors = 0, wr_count = 0, cycles = 0;
  int    q_addr[$];
  int    q_data[$];
  string q_tag[$];

  function automatic int entry_count(int d);
    return (d == 1) ? 4 : (d == 2) ? 16 : (d == 3) ? 256 : 0;
  endfunction

  function automatic int expect_entry(int f, int m, int i);
    longint w;
    int r, g, b, t;
    if (f == 0) begin
      w = mem[2*i] + 256 * mem[2*i+1];
      t = 0;
      r = int'((w / 2048) % 32) * 8;
      g = int'((w / 32) % 64) * 4;
      b = int'(w % 32) * 8;
    end else begin
      w = mem[4*i] + 256 * longint'(mem[4*i+1]) + 65536 * longint'(mem[4*i+2])
          + 16777216 * longint'(mem[4*i+3]);
      t = int'((w / 16777216) % 2);
      r = int'((w / 65536) % 256);
      g = int'((w / 256) % 256);
      b = int'(w % 256);
      if (f == 1) begin r = r / 8 * 8; g = g / 4 * 4; b = b / 8 * 8; end
      if (f == 2) begin r = r / 4 * 4; g = g / 4 * 4; b = b / 4 * 4; end
    end
    if (m != 0) begin
      r = int'(w % 256); g = r; b = r;
    end
    return t * 16777216 + r * 65536 + g * 256 + b;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_run(int f, int d, int m, string tag);
    for (int i = 0; i < entry_count(d); i++) begin
      q_addr.push_back(i);
      q_data.push_back(expect_entry(f, m, i));
      q_tag.push_back(tag);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rst_n && pal_we) begin
      wr_count++;
      if (q_addr.size() == 0) begin
        check(1'b0, "R9 unexpected write", int'(pal_waddr), -1);
      end else begin
        automatic int ea = q_addr.pop_front();
        automatic int ed = q_data.pop_front();
        automatic string et = q_tag.pop_front();
        check(int'(pal_waddr) == ea, {et, " addr"}, int'(pal_waddr), ea);
        check(int'(pal_wdata) == ed, {et, " data"}, int'(pal_wdata), ed);
      end
    end
  end

  task automatic wait_done();
    for (int k = 0; k < 400 && !done; k++) @(negedge clk);
  endtask

  task automatic run(int f, int d, int m, string tag);
    automatic int w0 = wr_count;
    push_run(f, d, m, tag);
    @(negedge clk);
    fmt = 2'(f); depth = 4'(d); mono = m[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(pal_we && pal_waddr == 8'd0 && !done, "R1 first write next cycle",
          int'(pal_we), 1);
    wait_done();
    check(done == 1'b1, "R8 done after run", int'(done), 1);
    check(wr_count - w0 == entry_count(d), "R1 entry count", wr_count - w0, entry_count(d));
    check(q_addr.size() == 0, "R1 queue drained", q_addr.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 1032; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3) ^ (i * i));
    repeat (3) @(negedge clk);
    check(!pal_we && !done, "R8 reset state", int'({pal_we, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(0, 2, 0, "R3 layout0");
    run(1, 2, 0, "R4 layout1");
    run(2, 1, 0, "R5 layout2 depth1");
    run(3, 3, 0, "R6 layout3 depth3");
    run(0, 3, 0, "R3 layout0 depth3");
    run(1, 2, 1, "R7 mono layout1");
    run(0, 1, 1, "R7 mono layout0");

    begin : r2_invalid_depth
      automatic int w0 = wr_count;
      fmt = 2'd3; depth = 4'd5; mono = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b1, "R2 done next cycle", int'(done), 1);
      repeat (5) @(negedge clk);
      check(wr_count == w0, "R2 no writes", wr_count - w0, 0);
    end

    begin : r9_start_busy
      automatic int w0;
      run(2, 2, 0, "R9 base");
      w0 = wr_count;
      push_run(3, 2, 0, "R9 run");
      fmt = 2'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (30) @(negedge clk);
      check(wr_count - w0 == 16, "R9 start while busy ignored", wr_count - w0, 16);
      check(done == 1'b1, "R9 done held", int'(done), 1);
    end

    begin : r10_auto
      push_run(1, 2, 0, "R10 auto rerun");
      fmt = 2'd1;
      @(negedge clk);
      check(pal_we && pal_waddr == 8'd0, "R10 auto start", int'(pal_we), 1);
      wait_done();
      check(q_addr.size() == 0, "R10 rerun complete", q_addr.size(), 0);
      repeat (5) @(negedge clk);
      check(!pal_we && done, "R10 no rerun when unchanged", int'(pal_we), 0);
    end

    begin : r11_sampled
      push_run(3, 2, 1, "R11 sampled run");
      push_run(0, 2, 1, "R11 rerun");
      fmt = 2'd3; mono = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      fmt = 2'd0; depth = 4'd2;
      repeat (60) @(negedge clk);
      check(q_addr.size() == 0 && done, "R11 both runs", q_addr.size(), 0);
    end

    check(q_addr.size() == 0, "R1 final queue", q_addr.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule